// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Sleep Handling

This block is the digital sequencer of a 10-bit successive-approximation converter. Software programs an 8-bit control word that holds an enable bit, a start/busy bit, a 4-bit input channel and a 2-bit conversion-clock source. The control word is bit-packed as `{src[1:0], chan[3:0], go, en}`, so `en` is bit 0, `go` is bit 1, `chan` is bits 5:2 and `src` is bits 7:6. The sequencer then drives a trial code to an external DAC/comparator pair, one bit per conversion-clock period, and keeps the upper eight bits of the final code in a result register.

The sequencer also watches the core's sleep status. When the internal RC strobe is the conversion clock, a conversion keeps running while the core sleeps. The block then either raises a wake request or powers the analog section down on its own. With any divided system clock, sleep kills the conversion at once. A compare unit's special event can start a conversion. Every such event also sends a one-cycle reset pulse to a companion timer, whether or not the converter is enabled.

Top module: `adc_sar_ctrl`

## Requirements
- R1: While `rst` is high, each clock edge zeroes the control word, drops any conversion, clears the interrupt flag, the wake request and the power-down latch, and raises `analog_pd`. Reset does not change `res_hi`.
- R2: Conversion runs MSB first. `dac_code` presents the trial code. `cmp_in` = 1 means the input is at or above the trial, and that keeps the bit. `res_hi` ends up holding bits 9:2 of the 10-bit value found.
- R3: With `src` = 00, 01 or 10, the conversion clock is the system clock divided by 2, 8 or 32. `go` reads 0 after 11 conversion periods (10 bits plus one load period), counted from the edge that accepts the start write.
- R4: With `src` = 11, each `rc_tick` strobe is one conversion period. The sequencer first waits 4 system clocks. With `rc_tick` held high, `go` clears 15 clocks after the start edge.
- R5: The interrupt flag sets on the same edge that `go` clears at completion. It stays set until a `flag_clr` pulse.
- R6: If `core_sleep` is high during a conversion and `src` is not 11, `go` clears on the next edge and `analog_pd` rises. The enable bit still reads 1, and neither `res_hi` nor the flag changes. `analog_pd` falls on the edge after sleep ends.
- R7: If an RC-clocked conversion completes during sleep with `irq_en` = 1, `wake_req` rises and stays high until `core_sleep` falls. `analog_pd` stays low.
- R8: If an RC-clocked conversion completes during sleep with `irq_en` = 0, `analog_pd` rises and `wake_req` stays low. The enable bit still reads 1. `analog_pd` falls after sleep ends.
- R9: If `evt_trig` is high with `cmp_mode` = 4'b1011 while the block is enabled and idle, a conversion starts: `go` reads 1 after that edge.
- R10: Every `evt_trig` with `cmp_mode` = 4'b1011 gives a one-cycle `tmr_rst` on the next cycle, even when the block is disabled. Any other mode gives neither a pulse nor a start.
- R11: A control write with `go` = 0 during a conversion aborts it. `res_hi` does not change and the flag stays clear.
- R12: `ch_sel` always equals the channel field, so the analog multiplexer sees the programmed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| flag_clr | input | 1 | Software clear of the interrupt flag |
| ctl_rdata | output | 8 | Control word readback |
| res_hi | output | 8 | Result high byte |
| core_sleep | input | 1 | Core is in sleep |
| irq_en | input | 1 | Converter interrupt enable |
| evt_trig | input | 1 | Special event from compare unit |
| cmp_mode | input | 4 | Mode of the compare unit |
| rc_tick | input | 1 | Synchronized internal RC strobe |
| cmp_in | input | 1 | Comparator decision |
| dac_code | output | 10 | Trial code to the DAC |
| ch_sel | output | 4 | Analog multiplexer select |
| irq_flag | output | 1 | Conversion-complete interrupt flag |
| wake_req | output | 1 | Wake request to the core |
| tmr_rst | output | 1 | Companion timer reset pulse |
| analog_pd | output | 1 | Analog section power-down |

## Verification
The hardest situation to reach is a conversion that completes while the core sleeps. It needs the RC source, a start write, and sleep asserted during the 4-clock start delay, before the first bit is resolved. The bench drives `core_sleep` on the negedge right after the start edge, with `rc_tick` held high, and repeats this with `irq_en` high and low. A behavioural comparator picks a per-channel value from `ch_sel`, so the full 1024-value sweep and the per-channel runs have exact expected bytes.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int unsigned CH_W = 4;

    typedef enum logic [1:0] {
        SRC_DIV_A = 2'b00,
        SRC_DIV_B = 2'b01,
        SRC_DIV_C = 2'b10,
        SRC_RC    = 2'b11
    } clk_src_e;

    typedef struct packed {
        clk_src_e          src;
        logic [CH_W-1:0]   chan;
        logic              go;
        logic              en;
    } ctl_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_RUN
    } phase_e;

    localparam logic [3:0] TRIG_MODE = 4'b1011;

    function automatic int unsigned src_div(clk_src_e s, int unsigned d0,
                                            int unsigned d1, int unsigned d2);
        case (s)
            SRC_DIV_A: return d0;
            SRC_DIV_B: return d1;
            SRC_DIV_C: return d2;
            default:   return 1;
        endcase
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned DIV0 = 2,
    parameter int unsigned DIV1 = 8,
    parameter int unsigned DIV2 = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  clk_src_e src,
    input  logic     rc_tick,
    output logic     tick
);
    localparam int unsigned MAXD = max3(DIV0, DIV1, DIV2);
    localparam int unsigned CW   = (MAXD > 2) ? $clog2(MAXD) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          div_hit;

    always_comb begin
        lim     = CW'(src_div(src, DIV0, DIV1, DIV2) - 1);
        div_hit = (cnt == lim);
        tick    = (src == SRC_RC) ? rc_tick : div_hit;
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (div_hit || src == SRC_RC)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // every divider is at least 2, so two divided strobes never abut
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (div_hit && !restart && src != SRC_RC) |=> (src == SRC_RC || !tick));

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
    parameter int unsigned NBITS = 10,
    parameter int unsigned RES_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  logic             cmp_in,
    output logic [NBITS-1:0] dac_code,
    output logic [RES_W-1:0] res_code,
    output logic             active,
    output logic             done
);
    localparam int unsigned IW = (NBITS > 2) ? $clog2(NBITS) : 1;

    logic             act;
    logic             loading;
    logic [IW-1:0]    idx;
    logic [NBITS-1:0] sar;
    logic [NBITS-1:0] trial;

    always_comb begin
        trial    = sar | (NBITS'(1) << idx);
        dac_code = (act && !loading) ? trial : sar;
        res_code = sar[NBITS-1 -: RES_W];
        done     = act && loading && tick && !abort;
        active   = act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= 1'b0;
            loading <= 1'b0;
            idx     <= '0;
            sar     <= '0;
        end else if (abort) begin
            act     <= 1'b0;
            loading <= 1'b0;
        end else if (start) begin
            act     <= 1'b1;
            loading <= 1'b0;
            idx     <= IW'(NBITS - 1);
            sar     <= '0;
        end else if (act && tick) begin
            if (loading) begin
                act <= 1'b0;
            end else begin
                sar[idx] <= cmp_in;
                if (idx == '0)
                    loading <= 1'b1;
                else
                    idx <= idx - 1'b1;
            end
        end
    end

    p_msb_first_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !abort) |=> (dac_code == (NBITS'(1) << (NBITS - 1))));

    p_lsb_then_load_r3: assert property (@(posedge clk) disable iff (rst)
        (act && !loading && tick && idx == '0 && !abort && !start) |=> (act && loading));

endmodule

// File: rtl/adc_trig_unit.sv
module adc_trig_unit
    import adc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt_trig,
    input  logic [3:0] cmp_mode,
    output logic       fire,
    output logic       tmr_rst
);
    always_comb fire = evt_trig && (cmp_mode == TRIG_MODE);

    always_ff @(posedge clk) begin
        if (rst) tmr_rst <= 1'b0;
        else     tmr_rst <= fire;
    end

    p_tmr_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_trig && cmp_mode == TRIG_MODE) |=> tmr_rst);

endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int unsigned NBITS      = 10,
    parameter int unsigned RES_W      = 8,
    parameter int unsigned DIV0       = 2,
    parameter int unsigned DIV1       = 8,
    parameter int unsigned DIV2       = 32,
    parameter int unsigned INSTR_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             flag_clr,
    output logic [7:0]       ctl_rdata,
    output logic [RES_W-1:0] res_hi,
    input  logic             core_sleep,
    input  logic             irq_en,
    input  logic             evt_trig,
    input  logic [3:0]       cmp_mode,
    input  logic             rc_tick,
    input  logic             cmp_in,
    output logic [NBITS-1:0] dac_code,
    output logic [CH_W-1:0]  ch_sel,
    output logic             irq_flag,
    output logic             wake_req,
    output logic             tmr_rst,
    output logic             analog_pd
);
    localparam int unsigned WCW = (INSTR_CLKS > 1) ? $clog2(INSTR_CLKS) : 1;

    ctl_t             ctl;
    ctl_t             wd;
    phase_e           phase;
    logic [WCW-1:0]   wait_cnt;
    logic             pd_lat;
    logic             busy, sleep_abort, sw_abort, kill;
    logic             start_sw, start_trig, start_any, wait_end;
    logic             eng_start, eng_done, eng_active, tick, trig_fire;
    clk_src_e         nxt_src;
    logic [RES_W-1:0] eng_res;

    always_comb begin
        wd          = ctl_t'(ctl_wdata);
        busy        = (phase != PH_IDLE);
        nxt_src     = ctl_we ? wd.src : ctl.src;
        sleep_abort = busy && core_sleep && (ctl.src != SRC_RC);
        sw_abort    = ctl_we && busy && !(wd.go && wd.en);
        kill        = sleep_abort || sw_abort;
        start_sw    = ctl_we && !busy && wd.go && wd.en;
        start_trig  = trig_fire && !busy && !ctl_we && ctl.en;
        start_any   = start_sw || start_trig;
        wait_end    = (phase == PH_WAIT) && (wait_cnt == WCW'(INSTR_CLKS - 1));
        eng_start   = !kill && ((start_any && nxt_src != SRC_RC) || wait_end);
    end

    adc_tick_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (eng_start),
        .src     (ctl.src),
        .rc_tick (rc_tick),
        .tick    (tick)
    );

    adc_sar_engine #(.NBITS(NBITS), .RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .abort    (kill),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .dac_code (dac_code),
        .res_code (eng_res),
        .active   (eng_active),
        .done     (eng_done)
    );

    adc_trig_unit u_trig (
        .clk      (clk),
        .rst      (rst),
        .evt_trig (evt_trig),
        .cmp_mode (cmp_mode),
        .fire     (trig_fire),
        .tmr_rst  (tmr_rst)
    );

    // sequencing phase and start delay
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            wait_cnt <= '0;
        end else if (kill || eng_done) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: if (start_any) begin
                    phase    <= (nxt_src == SRC_RC) ? PH_WAIT : PH_RUN;
                    wait_cnt <= '0;
                end
                PH_WAIT: if (wait_end) phase <= PH_RUN;
                         else          wait_cnt <= wait_cnt + 1'b1;
                default: phase <= phase;
            endcase
        end
    end

    // control word
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (ctl_we) begin
                ctl.en   <= wd.en;
                ctl.chan <= wd.chan;
                ctl.src  <= wd.src;
                ctl.go   <= busy ? (wd.go && wd.en) : start_sw;
            end
            if (start_trig)
                ctl.go <= 1'b1;
            if (kill || eng_done)
                ctl.go <= 1'b0;
        end
    end

    // flag, wake and power-down latch
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
            wake_req <= 1'b0;
            pd_lat   <= 1'b0;
        end else begin
            if (eng_done)      irq_flag <= 1'b1;
            else if (flag_clr) irq_flag <= 1'b0;

            if (eng_done && core_sleep && irq_en) wake_req <= 1'b1;
            else if (!core_sleep)                 wake_req <= 1'b0;

            if (sleep_abort || (eng_done && core_sleep && !irq_en)) pd_lat <= 1'b1;
            else if (!core_sleep)                                   pd_lat <= 1'b0;
        end
    end

    // result keeps its contents across reset
    always_ff @(posedge clk) begin
        if (eng_done) res_hi <= eng_res;
    end

    always_comb begin
        ctl_rdata = ctl;
        ch_sel    = ctl.chan;
        analog_pd = !ctl.en || pd_lat;
    end

    p_rst_clears_r1: assert property (@(posedge clk)
        rst |=> (ctl_rdata == 8'h00 && !irq_flag && analog_pd));

    p_rc_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT) |-> !eng_active);

    p_done_flag_r5: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> (irq_flag && !ctl.go));

    p_sleep_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && core_sleep && ctl.src != SRC_RC) |=> (!ctl.go && analog_pd));

    p_wake_r7: assert property (@(posedge clk) disable iff (rst)
        (eng_done && core_sleep && irq_en) |=> wake_req);

    p_pd_keep_en_r8: assert property (@(posedge clk) disable iff (rst)
        (eng_done && core_sleep && !irq_en && !ctl_we) |=> (analog_pd && ctl.en));

endmodule

// File: tb/tb_adc_sar_ctrl.sv
`timescale 1ns/1ps
module tb_adc_sar_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       flag_clr = 1'b0;
    logic [7:0] ctl_rdata;
    logic [7:0] res_hi;
    logic       core_sleep = 1'b0;
    logic       irq_en = 1'b0;
    logic       evt_trig = 1'b0;
    logic [3:0] cmp_mode = 4'b0000;
    logic       rc_tick = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [3:0] ch_sel;
    logic       irq_flag, wake_req, tmr_rst, analog_pd;

    logic [9:0] chv [16];
    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    adc_sar_ctrl dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .flag_clr(flag_clr), .ctl_rdata(ctl_rdata), .res_hi(res_hi),
        .core_sleep(core_sleep), .irq_en(irq_en), .evt_trig(evt_trig),
        .cmp_mode(cmp_mode), .rc_tick(rc_tick), .cmp_in(cmp_in),
        .dac_code(dac_code), .ch_sel(ch_sel), .irq_flag(irq_flag),
        .wake_req(wake_req), .tmr_rst(tmr_rst), .analog_pd(analog_pd)
    );

    // behavioural analog front end
    always_comb cmp_in = (chv[ch_sel] >= dac_code);

    function automatic logic [7:0] mk(input logic [1:0] src, input logic [3:0] ch,
                                      input logic go, input logic en);
        return {src, ch, go, en};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        ctl_wdata = d;
        ctl_we    = 1'b1;
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic wait_idle(output int k);
        k = 0;
        while (ctl_rdata[1] && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_conv(input logic [7:0] d, output int k);
        wr(d);
        wait_idle(k);
    endtask

    task automatic clr_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); evt_trig = 1'b1;
        @(negedge clk); evt_trig = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        int k;
        logic [7:0] keep;
        int divs [3];
        divs[0] = 2; divs[1] = 8; divs[2] = 32;
        for (int c = 0; c < 16; c++) chv[c] = 10'(c * 61 + 7);

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
        chk(analog_pd == 1'b1, "R1 pd", analog_pd, 1);
        chk(!irq_flag && !wake_req && !tmr_rst, "R1 flags", irq_flag, 0);
        rst = 1'b0;

        // R3 divider timing, R5 flag, R2 result
        chv[0] = 10'h2A5;
        for (int s = 0; s < 3; s++) begin
            run_conv(mk(2'(s), 4'd0, 1'b1, 1'b1), k);
            chk(k == 11 * divs[s], "R3 cycles", k, 11 * divs[s]);
            chk(irq_flag == 1'b1, "R5 flag at done", irq_flag, 1);
            chk(res_hi == 8'(10'h2A5 >> 2), "R2 result", res_hi, 10'h2A5 >> 2);
            clr_flag();
        end

        // R4 RC start delay
        rc_tick = 1'b1;
        run_conv(mk(2'b11, 4'd0, 1'b1, 1'b1), k);
        chk(k == 15, "R4 cycles", k, 15);
        rc_tick = 1'b0;

        // R5 flag holds until cleared
        repeat (20) @(negedge clk);
        chk(irq_flag == 1'b1, "R5 hold", irq_flag, 1);
        clr_flag();
        chk(irq_flag == 1'b0, "R5 clear", irq_flag, 0);

        // R2 exhaustive sweep
        for (int v = 0; v < 1024; v++) begin
            chv[1] = 10'(v);
            run_conv(mk(2'b00, 4'd1, 1'b1, 1'b1), k);
            chk(res_hi == 8'(v >> 2), "R2 sweep", res_hi, v >> 2);
        end

        // R12 channel routing
        for (int c = 0; c < 16; c++) begin
            if (c == 0) chv[0] = 10'(7);
            if (c == 1) chv[1] = 10'(68);
            run_conv(mk(2'b01, 4'(c), 1'b1, 1'b1), k);
            chk(ch_sel == 4'(c), "R12 ch_sel", ch_sel, c);
            chk(res_hi == 8'((c * 61 + 7) >> 2), "R12 result", res_hi, (c * 61 + 7) >> 2);
        end

        // R11 software abort
        clr_flag();
        keep = res_hi;
        chv[2] = 10'h3FF;
        wr(mk(2'b10, 4'd2, 1'b1, 1'b1));
        repeat (40) @(negedge clk);
        wr(mk(2'b10, 4'd2, 1'b0, 1'b1));
        chk(ctl_rdata[1] == 1'b0, "R11 go", ctl_rdata[1], 0);
        repeat (400) @(negedge clk);
        chk(res_hi == keep, "R11 result", res_hi, keep);
        chk(irq_flag == 1'b0, "R11 flag", irq_flag, 0);

        // R6 sleep with divided clock
        wr(mk(2'b01, 4'd2, 1'b1, 1'b1));
        repeat (20) @(negedge clk);
        core_sleep = 1'b1;
        @(negedge clk);
        chk(ctl_rdata[1] == 1'b0, "R6 go", ctl_rdata[1], 0);
        chk(analog_pd == 1'b1, "R6 pd", analog_pd, 1);
        chk(ctl_rdata[0] == 1'b1, "R6 en", ctl_rdata[0], 1);
        repeat (400) @(negedge clk);
        chk(res_hi == keep && !irq_flag, "R6 result", res_hi, keep);
        core_sleep = 1'b0;
        @(negedge clk);
        chk(analog_pd == 1'b0, "R6 pd release", analog_pd, 0);

        // R7 RC conversion in sleep with interrupt enabled
        rc_tick = 1'b1;
        irq_en  = 1'b1;
        chv[3]  = 10'h155;
        wr(mk(2'b11, 4'd3, 1'b1, 1'b1));
        core_sleep = 1'b1;
        wait_idle(k);
        chk(wake_req == 1'b1, "R7 wake", wake_req, 1);
        chk(irq_flag == 1'b1, "R7 flag", irq_flag, 1);
        chk(res_hi == 8'(10'h155 >> 2), "R7 result", res_hi, 10'h155 >> 2);
        chk(analog_pd == 1'b0, "R7 pd", analog_pd, 0);
        repeat (5) @(negedge clk);
        chk(wake_req == 1'b1, "R7 wake hold", wake_req, 1);
        core_sleep = 1'b0;
        @(negedge clk);
        chk(wake_req == 1'b0, "R7 wake release", wake_req, 0);

        // R8 RC conversion in sleep with interrupt disabled
        irq_en = 1'b0;
        clr_flag();
        chv[3] = 10'h0C3;
        wr(mk(2'b11, 4'd3, 1'b1, 1'b1));
        core_sleep = 1'b1;
        wait_idle(k);
        chk(wake_req == 1'b0, "R8 wake", wake_req, 0);
        chk(analog_pd == 1'b1, "R8 pd", analog_pd, 1);
        chk(ctl_rdata[0] == 1'b1, "R8 en", ctl_rdata[0], 1);
        chk(res_hi == 8'(10'h0C3 >> 2), "R8 result", res_hi, 10'h0C3 >> 2);
        core_sleep = 1'b0;
        @(negedge clk);
        chk(analog_pd == 1'b0, "R8 pd release", analog_pd, 0);
        rc_tick = 1'b0;

        // R9 / R10 special event
        chv[1] = 10'h2F0;
        wr(mk(2'b00, 4'd1, 1'b0, 1'b1));
        cmp_mode = 4'b1011;
        pulse_trig();
        chk(tmr_rst == 1'b1, "R10 pulse enabled", tmr_rst, 1);
        chk(ctl_rdata[1] == 1'b1, "R9 start", ctl_rdata[1], 1);
        @(negedge clk);
        chk(tmr_rst == 1'b0, "R10 one cycle", tmr_rst, 0);
        wait_idle(k);
        chk(res_hi == 8'(10'h2F0 >> 2), "R9 result", res_hi, 10'h2F0 >> 2);
        wr(8'h00);
        pulse_trig();
        chk(tmr_rst == 1'b1, "R10 pulse disabled", tmr_rst, 1);
        chk(ctl_rdata[1] == 1'b0, "R10 ignored", ctl_rdata[1], 0);
        wr(mk(2'b00, 4'd1, 1'b0, 1'b1));
        cmp_mode = 4'b0101;
        pulse_trig();
        chk(tmr_rst == 1'b0, "R10 other mode", tmr_rst, 0);
        chk(ctl_rdata[1] == 1'b0, "R10 no start", ctl_rdata[1], 0);

        // R1 reset keeps result
        keep = res_hi;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(ctl_rdata == 8'h00, "R1 ctl after run", ctl_rdata, 0);
        chk(res_hi == keep, "R1 result kept", res_hi, keep);
        chk(analog_pd == 1'b1 && !irq_flag, "R1 pd after run", analog_pd, 1);
        rst = 1'b0;

        done_flag = 1;
        summary();
    end
endmodule